// File: doc/BRIEF.md
# Configurable Input-to-Trigger OR Combiner

This block turns a vector of discrete, asynchronous input signals into a small set of trigger outputs. Each trigger output is built from its own selection of inputs: an input can be left out of an output or taken in. Before the selection is applied, each input can also be flipped in polarity, and that choice is made separately for every output. Each output is high whenever any of its selected and polarity-corrected inputs is high.

Software sets the selection and polarity masks through a simple word-addressed register slave. The slave has an address, write data, read and write strobes, read data and an acknowledge. Each output owns a group of four consecutive word addresses inside a 64-word window. The inputs are brought into the clock domain by a two-stage synchroniser, and each trigger output comes from a flip-flop.

Top module: `trig_or_combiner`

## Requirements
- R1: Trigger output n is the OR, over every input i, of (enable[n][i] AND (in[i] XOR invert[n][i])). Bit i of each mask refers to input i.
- R2: Setting invert bit i for one output flips the polarity of input i for that output alone. The same input keeps its own polarity in every other output.
- R3: Output n's registers start at word address 0xCF00 + 4*n. Offset 0 holds the enable mask and offset 1 holds the invert mask. Both masks can be read back exactly as they were written.
- R4: Offsets 2 and 3 of every group always read as zero. Writes to them change no mask and no output.
- R5: A read or write strobe whose address lies in 0xCF00..0xCF3F is acknowledged for exactly one cycle, in the cycle after the strobe. A strobe whose address lies outside that window gets no acknowledge and has no effect.
- R6: After reset every mask is zero, all trigger outputs are low and the acknowledge is low.
- R7: A change on an input reaches a trigger output after exactly three rising clock edges: two synchroniser stages and one output register.
- R8: Register groups for output numbers at or above NUM_OUT read as zero and ignore writes.
- R9: The outputs are independent. A mask written for one output changes no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | NUM_IN | Asynchronous input signals |
| busAddr | input | ADDR_W | Word address of the access |
| busWrData | input | NUM_IN | Data to write |
| busRdStrobe | input | 1 | Single-cycle read request |
| busWrStrobe | input | 1 | Single-cycle write request |
| busRdData | output | NUM_IN | Read data, valid while busAck is high |
| busAck | output | 1 | Acknowledge, one cycle after an in-window strobe |
| trigOut | output | NUM_OUT | Registered trigger outputs |

## Verification
The bus assertions assume that each strobe lasts a single cycle and that read and write strobes are never high together. The bench drives every access that way: it raises one strobe on a falling edge and drops it on the next falling edge. The mask-update assertion assumes that write data is stable while the write strobe is high, and the bus tasks hold the data steady for that whole cycle. The bench changes the inputs only on falling edges and keeps them stable across the three-edge latency window before it samples an output.

// File: rtl/trig_or_pkg.sv
package trig_or_pkg;
  localparam int GROUP_W = 4;   // 16 groups of 4 words in the 64-word window
  localparam int OFFS_W  = 2;

  typedef struct packed {
    logic                wrEnable;
    logic                wrInvert;
    logic                rdAccess;
    logic [GROUP_W-1:0]  group;
    logic [OFFS_W-1:0]   offset;
  } cfgCmd_t;
endpackage

// File: rtl/trig_or_ctrl.sv
module trig_or_ctrl
  import trig_or_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_OUT   = 4,
  parameter logic [15:0] BASE_ADDR = 16'hCF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdStrobe,
  input  logic              busWrStrobe,
  output cfgCmd_t           cmd,
  output logic              busAck
);
  localparam int WIN_LSB = GROUP_W + OFFS_W;

  logic inWindow;
  logic groupLive;
  logic [GROUP_W-1:0] groupSel;
  logic [OFFS_W-1:0]  offsetSel;

  assign inWindow  = (busAddr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign groupSel  = busAddr[WIN_LSB-1:OFFS_W];
  assign offsetSel = busAddr[OFFS_W-1:0];
  assign groupLive = (int'(groupSel) < NUM_OUT);

  always_comb begin
    cmd.group    = groupSel;
    cmd.offset   = offsetSel;
    cmd.rdAccess = busRdStrobe && inWindow;
    cmd.wrEnable = busWrStrobe && inWindow && groupLive && (offsetSel == 2'd0);
    cmd.wrInvert = busWrStrobe && inWindow && groupLive && (offsetSel == 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) busAck <= 1'b0;
    else       busAck <= (busRdStrobe || busWrStrobe) && inWindow;
  end

  // R5
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busRdStrobe || busWrStrobe) && inWindow) |=> busAck);
  // R5
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(busRdStrobe || busWrStrobe) || !inWindow) |=> !busAck);
endmodule

// File: rtl/trig_or_datapath.sv
module trig_or_datapath
  import trig_or_pkg::*;
#(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  trigIn,
  input  logic [NUM_IN-1:0]  busWrData,
  input  cfgCmd_t            cmd,
  output logic [NUM_IN-1:0]  busRdData,
  output logic [NUM_OUT-1:0] trigOut
);
  logic [NUM_IN-1:0] syncStage1, syncStage2;
  logic [NUM_IN-1:0] enMask  [NUM_OUT];
  logic [NUM_IN-1:0] invMask [NUM_OUT];
  logic [NUM_IN-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncStage1 <= '0;
      syncStage2 <= '0;
    end else begin
      syncStage1 <= trigIn;
      syncStage2 <= syncStage1;
    end
  end

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enMask[n]  <= '0;
        invMask[n] <= '0;
        trigOut[n] <= 1'b0;
      end else begin
        if (cmd.wrEnable && int'(cmd.group) == n) enMask[n]  <= busWrData;
        if (cmd.wrInvert && int'(cmd.group) == n) invMask[n] <= busWrData;
        trigOut[n] <= |(enMask[n] & (syncStage2 ^ invMask[n]));
      end
    end

    // R3
    en_update_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.wrEnable && int'(cmd.group) == n) |=> (enMask[n] == $past(busWrData)));
    // R6
    masked_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (enMask[n] == '0) |=> !trigOut[n]);
  end

  always_comb begin
    rdMux = '0;
    for (int n = 0; n < NUM_OUT; n++) begin
      if (int'(cmd.group) == n) begin
        if (cmd.offset == 2'd0) rdMux = enMask[n];
        else if (cmd.offset == 2'd1) rdMux = invMask[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdData <= '0;
    else if (cmd.rdAccess) busRdData <= rdMux;
    else                   busRdData <= '0;
  end

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdAccess && cmd.offset[1]) |=> (busRdData == '0));
endmodule

// File: rtl/trig_or_combiner.sv
module trig_or_combiner
  import trig_or_pkg::*;
#(
  parameter int          NUM_IN    = 32,
  parameter int          NUM_OUT   = 4,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hCF00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  trigIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_IN-1:0]  busWrData,
  input  logic               busRdStrobe,
  input  logic               busWrStrobe,
  output logic [NUM_IN-1:0]  busRdData,
  output logic               busAck,
  output logic [NUM_OUT-1:0] trigOut
);
  cfgCmd_t cmd;

  trig_or_ctrl #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busRdStrobe(busRdStrobe), .busWrStrobe(busWrStrobe),
    .cmd(cmd), .busAck(busAck)
  );

  trig_or_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .busWrData(busWrData),
    .cmd(cmd), .busRdData(busRdData), .trigOut(trigOut)
  );
endmodule

// File: tb/trig_or_combiner_bench.sv
module trig_or_combiner_bench;
  localparam int NUM_IN = 32;
  localparam int NUM_OUT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IN-1:0] trigIn = '0;
  logic [15:0] busAddr = '0;
  logic [NUM_IN-1:0] busWrData = '0;
  logic busRdStrobe = 1'b0, busWrStrobe = 1'b0;
  logic [NUM_IN-1:0] busRdData;
  logic busAck;
  logic [NUM_OUT-1:0] trigOut;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_or_combiner u_trig_or_combiner (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdStrobe(busRdStrobe), .busWrStrobe(busWrStrobe),
    .busRdData(busRdData), .busAck(busAck), .trigOut(trigOut)
  );

  task automatic check(string req, logic [63:0] actual, logic [63:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, actual, expected);
    end
  endtask

  // Strobe goes high on a falling edge; ack and data are sampled on the next one.
  task automatic busWrite(logic [15:0] addr, logic [31:0] data, output logic acked);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrStrobe = 1'b1;
    @(negedge clk);
    busWrStrobe = 1'b0;
    acked = busAck;
  endtask

  task automatic busRead(logic [15:0] addr, output logic [31:0] data, output logic acked);
    @(negedge clk);
    busAddr = addr; busRdStrobe = 1'b1;
    @(negedge clk);
    busRdStrobe = 1'b0;
    data = busRdData; acked = busAck;
  endtask

  // Input change settles at the output after three rising edges.
  task automatic setInputs(logic [31:0] v);
    @(negedge clk);
    trigIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    check("R6 outputs low", 64'(trigOut), 0);
    check("R6 ack low", 64'(busAck), 0);
    for (int n = 0; n < NUM_OUT; n++) begin
      logic [31:0] d; logic a;
      busRead(16'hCF00 + 16'(4*n), d, a);
      check("R6 enable zero", 64'(d), 0);
      busRead(16'hCF01 + 16'(4*n), d, a);
      check("R6 invert zero", 64'(d), 0);
    end
  endtask

  task automatic testRegisterMap();
    logic [31:0] d; logic a;
    busWrite(16'hCF04, 32'hA5A5_0F0F, a);
    check("R5 write ack", 64'(a), 1);
    busWrite(16'hCF05, 32'h1234_5678, a);
    busRead(16'hCF04, d, a);
    check("R3 enable readback", 64'(d), 64'hA5A5_0F0F);
    check("R5 read ack", 64'(a), 1);
    busRead(16'hCF05, d, a);
    check("R3 invert readback", 64'(d), 64'h1234_5678);
    @(negedge clk);
    check("R5 ack single cycle", 64'(busAck), 0);
    busWrite(16'hCF04, 0, a);
    busWrite(16'hCF05, 0, a);
  endtask

  task automatic testOrFunction();
    logic a;
    busWrite(16'hCF00, 32'h0000_0011, a);
    setInputs(32'h0000_0000);
    check("R1 no input high", 64'(trigOut[0]), 0);
    setInputs(32'h0000_0010);
    check("R1 bit4 enabled", 64'(trigOut[0]), 1);
    setInputs(32'h0000_0001);
    check("R1 bit0 enabled", 64'(trigOut[0]), 1);
    setInputs(32'hFFFF_FFEE);
    check("R1 only disabled bits high", 64'(trigOut[0]), 0);
    check("R9 other outputs idle", 64'(trigOut[3:1]), 0);
  endtask

  task automatic testInvert();
    logic a;
    busWrite(16'hCF08, 32'h0000_0100, a);
    busWrite(16'hCF09, 32'h0000_0100, a);
    setInputs(32'h0000_0000);
    check("R2 inverted low gives high", 64'(trigOut[2]), 1);
    check("R2 out0 not inverted", 64'(trigOut[0]), 0);
    busWrite(16'hCF00, 32'h0000_0100, a);
    setInputs(32'h0000_0100);
    check("R2 inverted high gives low", 64'(trigOut[2]), 0);
    check("R9 out0 sees raw input", 64'(trigOut[0]), 1);
    busWrite(16'hCF00, 0, a);
    busWrite(16'hCF08, 0, a);
    busWrite(16'hCF09, 0, a);
  endtask

  task automatic testLatency();
    logic a;
    busWrite(16'hCF0C, 32'h8000_0000, a);
    @(negedge clk); trigIn = 32'h0;
    repeat (3) @(negedge clk);
    @(negedge clk); trigIn = 32'h8000_0000;
    repeat (2) @(negedge clk);
    check("R7 not yet after two edges", 64'(trigOut[3]), 0);
    @(negedge clk);
    check("R7 visible after three edges", 64'(trigOut[3]), 1);
    busWrite(16'hCF0C, 0, a);
    trigIn = '0;
  endtask

  task automatic testReservedAndBounds();
    logic [31:0] d; logic a;
    busWrite(16'hCF00, 32'h0000_0003, a);
    busWrite(16'hCF02, 32'hFFFF_FFFF, a);
    check("R5 reserved write acked", 64'(a), 1);
    busRead(16'hCF02, d, a);
    check("R4 reserved reads zero", 64'(d), 0);
    busRead(16'hCF03, d, a);
    check("R4 offset3 reads zero", 64'(d), 0);
    busWrite(16'hCF14, 32'hFFFF_FFFF, a);
    busRead(16'hCF14, d, a);
    check("R8 unimplemented group zero", 64'(d), 0);
    check("R8 unimplemented group acked", 64'(a), 1);
    busWrite(16'hCF40, 32'hFFFF_FFFF, a);
    check("R5 out-of-window write no ack", 64'(a), 0);
    busRead(16'hCE00, d, a);
    check("R5 out-of-window read no ack", 64'(a), 0);
    busRead(16'hCF00, d, a);
    check("R4 enable untouched", 64'(d), 64'h3);
    busRead(16'hCF01, d, a);
    check("R4 invert untouched", 64'(d), 0);
    setInputs(32'h0);
    check("R4 output unchanged", 64'(trigOut), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegisterMap();
    testOrFunction();
    testInvert();
    testLatency();
    testReservedAndBounds();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule